// File: doc/BRIEF.md
# Mode-Filtered Overflow Event Counter

This block is a single programmable performance counter of width 2*HALF_W bits. Each cycle it may add one to its count when an event pulse arrives. It counts only when the counter slot is present, the global inhibit input is low, and the current privilege and virtualization state are not masked by an inhibit bit in the counter's own control register. Software can load either half of the count and rewrite the control register at any time.

The counter has two views of arithmetic, chosen by `view32`. In the wide view the whole count steps by one. In the split view the high half absorbs the step whenever the low half is saturated, and the low half stays saturated. In both views, a step from all ones wraps to zero. On a wrap the block sets a sticky overflow flag. If that flag was clear before the wrap, the block also emits a one-cycle request that sets the local counter-overflow interrupt pending bit in the core.

All outputs are registered. A change presented on the inputs before a rising clock edge is visible on the outputs just after that edge.

Top module: `mode_filt_ovf_ctr`

## Requirements
- R1: An event pulse is counted only when `ctr_present` is 1 and `glob_inhibit` is 0; otherwise `cnt_q` holds its value.
- R2: The control register bits are: bit 0 inhibits virtual-user, bit 1 inhibits virtual-supervisor, bit 2 inhibits user, bit 3 inhibits supervisor, bit 4 inhibits machine, and bit 5 is the overflow flag. For `priv_mode`, 2'b11 is machine mode (virtualization is ignored), 2'b01 is supervisor mode and 2'b00 is user mode. In supervisor or user mode, `virt_on` chooses between the virtual bit and the plain bit. The value 2'b10 never counts. A set inhibit bit that matches the current mode suppresses counting.
- R3: With `view32`=0, an enabled event adds one to the full count, and all ones becomes zero.
- R4: With `view32`=1, an enabled event adds one to the low half unless the low half is all ones. In that case the high half adds one and the low half stays all ones. When both halves are all ones, both become zero.
- R5: A wrap to zero while the overflow flag is 0 sets the flag. The same edge pulses `ovf_irq_set` high for exactly one cycle.
- R6: A wrap while the overflow flag is already 1 leaves the flag at 1 and produces no pulse.
- R7: `ctl_wr_en` loads `ctl_wr_data` into the control register. The overflow flag is cleared only by such a write with bit 5 at 0.
- R8: A cycle with `cnt_wr_lo` or `cnt_wr_hi` loads `cnt_wr_data` into the selected half or halves and cancels any increment in that cycle.
- R9: When a wrap and a control write fall in the same cycle, the inhibit check uses the control value from before the write. The overflow flag ends at 1 whatever bit 5 of the written data is.
- R10: A synchronous reset clears the count, the control register and `ovf_irq_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 1 | One event this cycle |
| priv_mode | input | 2 | Current privilege level |
| virt_on | input | 1 | Hart runs virtualized |
| glob_inhibit | input | 1 | This counter's bit in the global inhibit register |
| ctr_present | input | 1 | Counter slot is implemented |
| view32 | input | 1 | 1 selects split-half arithmetic |
| ctl_wr_en | input | 1 | Write the control register |
| ctl_wr_data | input | 6 | Control write data |
| cnt_wr_lo | input | 1 | Write the low half of the count |
| cnt_wr_hi | input | 1 | Write the high half of the count |
| cnt_wr_data | input | HALF_W | Count half write data |
| cnt_q | output | 2*HALF_W | Current count |
| ctl_q | output | 6 | Current control register |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq_set | output | 1 | One-cycle request to set overflow interrupt pending |

## Verification
A hardware wrap and a software write of the control register can land on the same edge. In that case the flag set by the wrap must win over a written zero, and the inhibit bits being written must not yet affect that cycle's count. The bench provokes this with a count preloaded to all ones: one event arrives together with a control write that clears bit 5 and sets the machine inhibit while in machine mode. It then expects a zero count, a set flag, a pulse and the new inhibit bits. A count write colliding with an event is a second such case. It is provoked both directly and by random stimulus, and is judged against the bench model's rule that the write wins.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  localparam int CTL_W      = 6;
  localparam int BIT_INH_VU = 0;
  localparam int BIT_INH_VS = 1;
  localparam int BIT_INH_U  = 2;
  localparam int BIT_INH_S  = 3;
  localparam int BIT_INH_M  = 4;
  localparam int BIT_OVF    = 5;
endpackage

// File: rtl/ctr_mode_gate.sv
module ctr_mode_gate
  import ctr_pkg::*;
(
  input  logic [1:0]       priv_mode,
  input  logic             virt_on,
  input  logic [CTL_W-1:0] ctl,
  output logic             blocked
);
  always_comb begin
    unique case (priv_e'(priv_mode))
      PRIV_M:  blocked = ctl[BIT_INH_M];
      PRIV_S:  blocked = virt_on ? ctl[BIT_INH_VS] : ctl[BIT_INH_S];
      PRIV_U:  blocked = virt_on ? ctl[BIT_INH_VU] : ctl[BIT_INH_U];
      default: blocked = 1'b1;
    endcase
  end
endmodule

// File: rtl/ctr_step.sv
module ctr_step #(
  parameter int HALF_W = 32
) (
  input  logic [2*HALF_W-1:0] cur,
  input  logic                view32,
  output logic [2*HALF_W-1:0] nxt,
  output logic                wrap
);
  localparam int FULL_W = 2 * HALF_W;

  logic [HALF_W-1:0] lo, hi;
  logic              lo_sat, hi_sat;

  assign lo     = cur[HALF_W-1:0];
  assign hi     = cur[FULL_W-1:HALF_W];
  assign lo_sat = &lo;
  assign hi_sat = &hi;
  assign wrap   = lo_sat & hi_sat;

  always_comb begin
    if (wrap) begin
      nxt = '0;
    end else if (!view32) begin
      nxt = cur + FULL_W'(1);
    end else if (lo_sat) begin
      nxt = {hi + HALF_W'(1), lo};
    end else begin
      nxt = {hi, lo + HALF_W'(1)};
    end
  end
endmodule

// File: rtl/ctr_ovf_ctl.sv
module ctr_ovf_ctl
  import ctr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  input  logic             wrap_evt,
  output logic [CTL_W-1:0] ctl_q,
  output logic             irq_set
);
  logic [CTL_W-1:0] ctl_nxt;

  always_comb begin
    ctl_nxt = ctl_wr_en ? ctl_wr_data : ctl_q;
    if (wrap_evt) ctl_nxt[BIT_OVF] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      irq_set <= 1'b0;
    end else begin
      ctl_q   <= ctl_nxt;
      irq_set <= wrap_evt & ~ctl_q[BIT_OVF];
    end
  end
endmodule

// File: rtl/mode_filt_ovf_ctr.sv
module mode_filt_ovf_ctr
  import ctr_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                evt_pulse,
  input  logic [1:0]          priv_mode,
  input  logic                virt_on,
  input  logic                glob_inhibit,
  input  logic                ctr_present,
  input  logic                view32,
  input  logic                ctl_wr_en,
  input  logic [CTL_W-1:0]    ctl_wr_data,
  input  logic                cnt_wr_lo,
  input  logic                cnt_wr_hi,
  input  logic [HALF_W-1:0]   cnt_wr_data,
  output logic [2*HALF_W-1:0] cnt_q,
  output logic [CTL_W-1:0]    ctl_q,
  output logic                ovf_flag,
  output logic                ovf_irq_set
);
  localparam int FULL_W = 2 * HALF_W;

  logic              mode_blocked;
  logic              inc;
  logic              step_wrap;
  logic [FULL_W-1:0] step_nxt;

  ctr_mode_gate u_gate (
    .priv_mode (priv_mode),
    .virt_on   (virt_on),
    .ctl       (ctl_q),
    .blocked   (mode_blocked)
  );

  ctr_step #(.HALF_W(HALF_W)) u_step (
    .cur    (cnt_q),
    .view32 (view32),
    .nxt    (step_nxt),
    .wrap   (step_wrap)
  );

  assign inc = evt_pulse & ctr_present & ~glob_inhibit & ~mode_blocked
             & ~cnt_wr_lo & ~cnt_wr_hi;

  ctr_ovf_ctl u_ovf (
    .clk         (clk),
    .rst         (rst),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_wr_data (ctl_wr_data),
    .wrap_evt    (inc & step_wrap),
    .ctl_q       (ctl_q),
    .irq_set     (ovf_irq_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_wr_lo || cnt_wr_hi) begin
      if (cnt_wr_lo) cnt_q[HALF_W-1:0]      <= cnt_wr_data;
      if (cnt_wr_hi) cnt_q[FULL_W-1:HALF_W] <= cnt_wr_data;
    end else if (inc) begin
      cnt_q <= step_nxt;
    end
  end

  assign ovf_flag = ctl_q[BIT_OVF];
endmodule

// File: rtl/ovf_ctr_checker.sv
module ovf_ctr_checker #(
  parameter int HALF_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                glob_inhibit,
  input logic                ctl_wr_en,
  input logic                cnt_wr_lo,
  input logic                cnt_wr_hi,
  input logic [HALF_W-1:0]   cnt_wr_data,
  input logic [2*HALF_W-1:0] cnt_q,
  input logic                ovf_flag,
  input logic                ovf_irq_set
);
  a_r1_hold_when_inhibited: assert property (@(posedge clk) disable iff (rst)
    (glob_inhibit && !cnt_wr_lo && !cnt_wr_hi) |=> (cnt_q == $past(cnt_q)));

  a_r5_pulse_on_zero_wrap: assert property (@(posedge clk) disable iff (rst)
    ovf_irq_set |-> (cnt_q == '0 && ovf_flag));

  a_r5_pulse_single: assert property (@(posedge clk) disable iff (rst)
    ovf_irq_set |=> !ovf_irq_set);

  a_r6_no_pulse_flag_set: assert property (@(posedge clk) disable iff (rst)
    ovf_irq_set |-> !$past(ovf_flag));

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ctl_wr_en) |=> ovf_flag);

  a_r8_low_write_wins: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_lo |=> (cnt_q[HALF_W-1:0] == $past(cnt_wr_data)));
endmodule

bind mode_filt_ovf_ctr ovf_ctr_checker #(.HALF_W(HALF_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .glob_inhibit (glob_inhibit),
  .ctl_wr_en    (ctl_wr_en),
  .cnt_wr_lo    (cnt_wr_lo),
  .cnt_wr_hi    (cnt_wr_hi),
  .cnt_wr_data  (cnt_wr_data),
  .cnt_q        (cnt_q),
  .ovf_flag     (ovf_flag),
  .ovf_irq_set  (ovf_irq_set)
);

// File: tb/test_mode_filt_ovf_ctr.sv
module test_mode_filt_ovf_ctr;
  localparam int HW = 32;
  localparam int FW = 2 * HW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          evt_pulse = 0, virt_on = 0, glob_inhibit = 0, ctr_present = 1, view32 = 0;
  logic [1:0]    priv_mode = 2'b11;
  logic          ctl_wr_en = 0, cnt_wr_lo = 0, cnt_wr_hi = 0;
  logic [5:0]    ctl_wr_data = '0;
  logic [HW-1:0] cnt_wr_data = '0;
  logic [FW-1:0] cnt_q;
  logic [5:0]    ctl_q;
  logic          ovf_flag, ovf_irq_set;

  int n_chk = 0;
  int n_bad = 0;
  logic [FW-1:0] m_cnt = '0;
  logic [5:0]    m_ctl = '0;

  always #2 clk = ~clk;

  mode_filt_ovf_ctr #(.HALF_W(HW)) i_mode_filt_ovf_ctr (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .priv_mode(priv_mode),
    .virt_on(virt_on), .glob_inhibit(glob_inhibit), .ctr_present(ctr_present),
    .view32(view32), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi), .cnt_wr_data(cnt_wr_data),
    .cnt_q(cnt_q), .ctl_q(ctl_q), .ovf_flag(ovf_flag), .ovf_irq_set(ovf_irq_set)
  );

  function automatic logic f_blocked(input logic [1:0] p, input logic v, input logic [5:0] c);
    case (p)
      2'b11:   return c[4];
      2'b01:   return v ? c[1] : c[3];
      2'b00:   return v ? c[0] : c[2];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [FW:0] f_step(input logic [FW-1:0] c, input logic v32);
    logic [HW-1:0] lo, hi;
    lo = c[HW-1:0];
    hi = c[FW-1:HW];
    if (&c)      return {1'b1, {FW{1'b0}}};
    if (!v32)    return {1'b0, c + FW'(1)};
    if (&lo)     return {1'b0, hi + HW'(1), lo};
    return {1'b0, hi, lo + HW'(1)};
  endfunction

  task automatic check(input string tag, input logic [FW+7:0] act, input logic [FW+7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual cnt=%h ctl=%h irq=%b  expected cnt=%h ctl=%h irq=%b", tag,
               act[FW+6:7], act[6:1], act[0], exp[FW+6:7], exp[6:1], exp[0]);
    end
  endtask

  task automatic apply(input logic ev, input logic [1:0] pm, input logic vo, input logic gi,
                       input logic pr, input logic v32, input logic cwe, input logic [5:0] cwd,
                       input logic wl, input logic wh, input logic [HW-1:0] wd, input string tag);
    logic inc, wrap, irq_e;
    logic [FW:0] st;
    @(negedge clk);
    evt_pulse = ev; priv_mode = pm; virt_on = vo; glob_inhibit = gi; ctr_present = pr;
    view32 = v32; ctl_wr_en = cwe; ctl_wr_data = cwd; cnt_wr_lo = wl; cnt_wr_hi = wh;
    cnt_wr_data = wd;
    inc   = ev & pr & ~gi & ~f_blocked(pm, vo, m_ctl) & ~wl & ~wh;
    st    = f_step(m_cnt, v32);
    wrap  = inc & st[FW];
    irq_e = wrap & ~m_ctl[5];
    if (wl) m_cnt[HW-1:0] = wd;
    if (wh) m_cnt[FW-1:HW] = wd;
    if (inc) m_cnt = st[FW-1:0];
    if (cwe) m_ctl = cwd;
    if (wrap) m_ctl[5] = 1'b1;
    @(posedge clk);
    #1;
    check(tag, {1'b0, cnt_q, ctl_q, ovf_irq_set}, {1'b0, m_cnt, m_ctl, irq_e});
    if (ovf_flag !== m_ctl[5]) check({tag, " flag"}, 1, 0);
  endtask

  localparam logic [HW-1:0] ONES = '1;

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check("R10 reset", {1'b0, cnt_q, ctl_q, ovf_irq_set}, '0);
    // R3 wide-view counting in machine mode
    repeat (3) apply(1, 2'b11, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R3 count");
    // R1 gating
    apply(1, 2'b11, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R1 global inhibit");
    apply(1, 2'b11, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 not present");
    // R2 mode filters, one bit at a time
    apply(0, 2'b11, 0, 0, 1, 0, 1, 6'h10, 0, 0, 0, "R7 ctl write");
    apply(1, 2'b11, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R2 M inhibited");
    apply(1, 2'b01, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R2 S counts");
    apply(0, 2'b11, 0, 0, 1, 0, 1, 6'h08, 0, 0, 0, "R7 ctl write");
    apply(1, 2'b01, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R2 S inhibited");
    apply(1, 2'b01, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R2 VS counts");
    apply(0, 2'b11, 0, 0, 1, 0, 1, 6'h01, 0, 0, 0, "R7 ctl write");
    apply(1, 2'b00, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R2 VU inhibited");
    apply(1, 2'b00, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R2 U counts");
    apply(1, 2'b10, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R2 reserved mode");
    apply(0, 2'b11, 0, 0, 1, 0, 1, 6'h00, 0, 0, 0, "R7 ctl clear");
    // R8 write beats increment
    apply(1, 2'b11, 0, 0, 1, 0, 0, 0, 1, 0, 32'h1234_5678, "R8 low write");
    apply(1, 2'b11, 0, 0, 1, 0, 0, 0, 0, 1, 32'h0000_00AB, "R8 high write");
    // R3 and R5: wide wrap
    apply(0, 2'b11, 0, 0, 1, 0, 0, 0, 1, 1, ONES, "R8 preload");
    apply(1, 2'b11, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R5 wrap raises");
    apply(0, 2'b11, 0, 0, 1, 0, 0, 0, 1, 1, ONES, "R5 pulse drops");
    apply(1, 2'b11, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R6 wrap flag set");
    apply(0, 2'b11, 0, 0, 1, 0, 1, 6'h00, 0, 0, 0, "R7 flag clear");
    // R3 carry in wide view
    apply(0, 2'b11, 0, 0, 1, 0, 0, 0, 1, 1, 32'h7, "R8 preload");
    apply(0, 2'b11, 0, 0, 1, 0, 0, 0, 1, 0, ONES, "R8 preload");
    apply(1, 2'b11, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R3 carry");
    // R4 split view
    apply(0, 2'b11, 0, 0, 1, 1, 0, 0, 1, 0, ONES, "R8 preload");
    apply(1, 2'b11, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R4 low saturated");
    apply(0, 2'b11, 0, 0, 1, 1, 0, 0, 0, 1, ONES, "R8 preload");
    apply(1, 2'b11, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R4 split wrap");
    apply(0, 2'b11, 0, 0, 1, 1, 1, 6'h00, 1, 1, ONES, "R7 clear");
    // R9 wrap collides with ctl write
    apply(1, 2'b11, 0, 0, 1, 0, 1, 6'h10, 0, 0, 0, "R9 wrap vs ctl write");
    apply(0, 2'b11, 0, 0, 1, 0, 1, 6'h00, 0, 0, 0, "R7 clear");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [HW-1:0] wd;
      logic [1:0] sel;
      sel = 2'($urandom_range(3));
      wd = (sel == 0) ? ONES : (sel == 1) ? ONES - HW'(1) : (sel == 2) ? HW'($urandom) : '0;
      apply($urandom_range(7) != 0, 2'($urandom_range(3)), 1'($urandom_range(1)),
            $urandom_range(9) == 0, $urandom_range(15) != 0, 1'($urandom_range(1)),
            $urandom_range(11) == 0, 6'($urandom_range(63)) & 6'h3F & (($urandom_range(3) == 0) ? 6'h3F : 6'h20),
            $urandom_range(5) == 0, $urandom_range(5) == 0, wd,
            "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule